// File: doc/BRIEF.md
# Two-wire serial EEPROM slave protocol engine

This block is the bus-facing half of a 256-byte two-wire serial memory. A fast system clock oversamples the serial clock and data lines. The block finds START and STOP conditions and shifts in the select, address and data bytes, most significant bit first. It pulls the data line low to acknowledge, and it shifts read data out. A separate page-buffer block holds the bytes and performs the self-timed programming. This engine talks to it over a byte read/write port and a commit strobe, and it stays off the bus while the page buffer reports busy.

One chip-enable address on the bus carries two device-type codes. One code reaches the memory array. The other reaches a protection register, which takes writes only; its address and data bytes are accepted and then dropped. Byte write, page write, current-address read, random read and sequential read are all supported. The internal address counter is shared by reads and writes.

Top module: `tw_eeprom_slave`

## Requirements
- R1: After reset, sda_oe_o is 0 and neither mem_we_o nor commit_o has pulsed.
- R2: The slave acknowledges a select byte only under two conditions. Bits 3..1 of the byte must equal chip_sel_i[2:0]. Bits 7..4 must be 1010 (array), or 0110 (protection register) with bit 0 = 0. Bit 0 = 1 means read. On any other select byte the slave releases the line and acknowledges nothing more until the next START.
- R3: In a byte write, each of the select, address and data bytes is acknowledged. The data byte produces one mem_we_o pulse that carries the loaded address and the data. A STOP placed straight after that data acknowledge gives one commit_o pulse with commit_prot_o = 0.
- R4: In a page write, each further data byte goes to the next address. The low 4 address bits count modulo 16 and the upper 4 bits stay fixed.
- R5: A STOP that does not directly follow a data-byte acknowledge gives no commit_o. Two cases are covered: a STOP after the address byte only, and a STOP one or more bits into a later byte. A write of the address alone still loads the address counter.
- R6: A current-address read returns the byte at the address counter, MSB first. The counter then steps up by one.
- R7: A random read returns the byte at the address given in the preceding dummy write. The read follows a repeated START and a select byte with bit 0 = 1.
- R8: In a sequential read, a master ACK leads to the byte at the next address, and the address wraps from FFh to 00h. A master NoAck ends the transfer: the slave drives nothing until the next START.
- R9: A protection-register write (type 0110, bit 0 = 0) acknowledges its address and data bytes but makes no mem_we_o pulse. A STOP after the data acknowledge gives commit_o with commit_prot_o = 1. A protection-register select with bit 0 = 1 is not acknowledged.
- R10: While busy_i is high, the slave ignores the bus and does not acknowledge a select byte. Once busy_i falls, the same select is acknowledged.
- R11: A START seen in the middle of a byte abandons that byte. Decoding begins again with a fresh select byte.
- R12: sda_oe_o changes only while the serial clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8 times the serial clock rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the bus |
| chip_sel_i | input | 3 | Strapped chip-enable address, compared with select bits 3..1 |
| busy_i | input | 1 | Page buffer is running its self-timed write |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| mem_addr_o | output | 8 | Address counter, used for both read and write |
| mem_rdata_i | input | 8 | Byte at mem_addr_o, valid in the same cycle |
| mem_we_o | output | 1 | Strobe for one byte into the page buffer |
| mem_wdata_o | output | 8 | Byte written with mem_we_o |
| commit_o | output | 1 | Starts the self-timed write cycle |
| commit_prot_o | output | 1 | With commit_o: the write targets the protection register |

## Verification
The assertions assume that the bus master changes the data line only while the serial clock is low, except when it makes START and STOP. They also assume that each serial clock level lasts for more than the synchroniser delay, and that busy_i rises only after a commit, when the line is already released. The bench master holds each clock level for 10 system cycles. It waits 2 cycles after every falling clock edge before it moves the data line, and it releases the line during every slave slot. The page-buffer model raises busy_i only on commit_o. Random transfers pick addresses and lengths from a fixed seed and always finish with a full stop or a NoAck.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam logic [3:0] TYPE_MEM  = 4'b1010;
  localparam logic [3:0] TYPE_PROT = 4'b0110;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_RACK
  } state_t;

  typedef enum logic [1:0] {
    K_DEV, K_ADDR, K_DATA
  } kind_t;
endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] line_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  localparam int DEPTH = STAGES + 1;

  for (genvar g = 0; g < N; g++) begin : g_line
    logic [DEPTH-1:0] pipe_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= '1;
      else         pipe_q <= {pipe_q[DEPTH-2:0], line_i[g]};
    end
    assign lvl_o[g]  = pipe_q[DEPTH-2];
    assign rise_o[g] = pipe_q[DEPTH-2] & ~pipe_q[DEPTH-1];
    assign fall_o[g] = ~pipe_q[DEPTH-2] & pipe_q[DEPTH-1];
  end
endmodule

// File: rtl/tw_addr_ctr.sv
module tw_addr_ctr #(
  parameter int AW = 8,
  parameter int PW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_i,
  input  logic [AW-1:0] ld_val_i,
  input  logic          inc_page_i,
  input  logic          inc_all_i,
  output logic [AW-1:0] addr_o
);
  localparam logic [AW-1:0] ADDR_MAX = '1;

  logic [AW-1:0] addr_q;
  logic [PW-1:0] low_nxt;

  assign low_nxt = addr_q[PW-1:0] + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         addr_q <= '0;
    else if (ld_i)       addr_q <= ld_val_i;
    else if (inc_page_i) addr_q <= {addr_q[AW-1:PW], low_nxt};
    else if (inc_all_i)  addr_q <= addr_q + 1'b1;
  end

  assign addr_o = addr_q;

  p_page_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_page_i && !ld_i) |=> (addr_q[AW-1:PW] == $past(addr_q[AW-1:PW])));

  p_read_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_all_i && !ld_i && !inc_page_i && addr_q == ADDR_MAX) |=> (addr_q == '0));
endmodule

// File: rtl/tw_eeprom_slave.sv
module tw_eeprom_slave
  import tw_pkg::*;
#(
  parameter int AW     = 8,
  parameter int PW     = 4,
  parameter int STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic [2:0]    chip_sel_i,
  input  logic          busy_i,
  output logic          sda_oe_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [7:0]    mem_rdata_i,
  output logic          mem_we_o,
  output logic [7:0]    mem_wdata_o,
  output logic          commit_o,
  output logic          commit_prot_o
);
  logic [1:0] lvl, rise, fall;
  logic scl_lvl, scl_rise, scl_fall, sda_lvl;
  logic start_d, stop_d, quiet;

  tw_line_sync #(.N(2), .STAGES(STAGES)) i_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .line_i({sda_i, scl_i}),
    .lvl_o (lvl), .rise_o(rise), .fall_o(fall)
  );

  assign scl_lvl  = lvl[0];
  assign scl_rise = rise[0];
  assign scl_fall = fall[0];
  assign sda_lvl  = lvl[1];
  assign start_d  = fall[1] & scl_lvl & ~scl_rise;
  assign stop_d   = rise[1] & scl_lvl & ~scl_rise;
  assign quiet    = ~busy_i & ~start_d & ~stop_d;

  state_t     state_q;
  kind_t      kind_q;
  logic [3:0] cnt_q;
  logic [7:0] sr_q;
  logic       oe_q, is_read_q, prot_q, got_data_q;
  logic       dev_hit, byte_end, ld, inc_page, inc_all;

  assign dev_hit = (sr_q[3:1] == chip_sel_i) &&
                   ((sr_q[7:4] == TYPE_MEM) || (sr_q[7:4] == TYPE_PROT && !sr_q[0]));
  assign byte_end = quiet && state_q == ST_RX && scl_fall && cnt_q == 4'd8;
  assign ld       = byte_end && kind_q == K_ADDR && !prot_q;
  assign inc_page = byte_end && kind_q == K_DATA && !prot_q;
  assign inc_all  = quiet && state_q == ST_TX && scl_fall && cnt_q == 4'd8;

  tw_addr_ctr #(.AW(AW), .PW(PW)) i_ctr (
    .clk_i (clk_i), .rst_ni(rst_ni), .ld_i(ld), .ld_val_i(sr_q[AW-1:0]),
    .inc_page_i(inc_page), .inc_all_i(inc_all), .addr_o(mem_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE; kind_q <= K_DEV; cnt_q <= '0; sr_q <= '0;
      oe_q <= 1'b0; is_read_q <= 1'b0; prot_q <= 1'b0; got_data_q <= 1'b0;
    end else if (busy_i) begin
      state_q <= ST_IDLE; oe_q <= 1'b0; got_data_q <= 1'b0;
    end else if (start_d) begin
      state_q <= ST_RX; kind_q <= K_DEV; cnt_q <= '0;
      oe_q <= 1'b0; got_data_q <= 1'b0;
    end else if (stop_d) begin
      state_q <= ST_IDLE; oe_q <= 1'b0; got_data_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_RX: begin
          if (scl_rise) begin
            sr_q  <= {sr_q[6:0], sda_lvl};
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q != 4'd0) got_data_q <= 1'b0;  // past the stop slot
          end else if (scl_fall && cnt_q == 4'd8) begin
            cnt_q <= '0;
            if (kind_q == K_DEV) begin
              if (dev_hit) begin
                state_q   <= ST_ACK;
                oe_q      <= 1'b1;
                is_read_q <= sr_q[0];
                prot_q    <= (sr_q[7:4] == TYPE_PROT);
              end else begin
                state_q <= ST_IDLE;
              end
            end else begin
              state_q <= ST_ACK;
              oe_q    <= 1'b1;
              if (kind_q == K_DATA) got_data_q <= 1'b1;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            cnt_q <= '0;
            if (kind_q == K_DEV && is_read_q) begin
              state_q <= ST_TX;
              sr_q    <= mem_rdata_i;
              oe_q    <= ~mem_rdata_i[7];
            end else begin
              state_q <= ST_RX;
              oe_q    <= 1'b0;
              kind_q  <= (kind_q == K_DEV) ? K_ADDR : K_DATA;
            end
          end
        end
        ST_TX: begin
          if (scl_rise) cnt_q <= cnt_q + 1'b1;
          else if (scl_fall) begin
            if (cnt_q == 4'd8) begin
              state_q <= ST_RACK;
              oe_q    <= 1'b0;
            end else begin
              sr_q <= {sr_q[6:0], 1'b0};
              oe_q <= ~sr_q[6];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise && sda_lvl) state_q <= ST_IDLE;
          else if (scl_fall) begin
            state_q <= ST_TX;
            cnt_q   <= '0;
            sr_q    <= mem_rdata_i;
            oe_q    <= ~mem_rdata_i[7];
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o      = oe_q;
  assign mem_we_o      = inc_page;
  assign mem_wdata_o   = sr_q;
  assign commit_o      = stop_d && got_data_q && !busy_i;
  assign commit_prot_o = prot_q;

  p_oe_rise_scl_low_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_lvl);

  p_busy_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> !sda_oe_o);

  p_commit_released_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> !sda_oe_o);

  p_nack_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RACK && scl_rise && sda_lvl && quiet) |=> !sda_oe_o);
endmodule

// File: tb/test_tw_eeprom_slave.sv
`timescale 1ns/1ps
module test_tw_eeprom_slave;
  localparam int H    = 10;
  localparam int BUSY = 600;
  localparam logic [2:0] CS = 3'b101;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, msda = 1'b1;
  logic busy = 1'b0;
  logic sda_oe, mem_we, commit, commit_prot;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;
  logic line;

  logic [7:0] mem [256];
  logic [7:0] expm [256];
  logic [7:0] pend [256];
  logic       pv [256];
  logic [7:0] exp_ptr;
  int checks = 0, fails = 0, we_cnt = 0, commit_cnt = 0, busy_cnt = 0, viol = 0;
  logic last_prot = 1'b0, oe_prev = 1'b0;
  bit done = 0;

  always #2.5 clk = ~clk;
  assign line      = msda & ~sda_oe;
  assign mem_rdata = mem[mem_addr];

  tw_eeprom_slave i_tw_eeprom_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(line), .chip_sel_i(CS),
    .busy_i(busy), .sda_oe_o(sda_oe), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .mem_we_o(mem_we), .mem_wdata_o(mem_wdata), .commit_o(commit),
    .commit_prot_o(commit_prot)
  );

  // page-buffer model and drive-timing monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_we) begin pend[mem_addr] = mem_wdata; pv[mem_addr] = 1'b1; we_cnt++; end
      if (commit) begin
        commit_cnt++; last_prot = commit_prot;
        if (!commit_prot) for (int i = 0; i < 256; i++) if (pv[i]) mem[i] = pend[i];
        for (int i = 0; i < 256; i++) pv[i] = 1'b0;
        busy_cnt = BUSY;
      end else if (busy_cnt > 0) busy_cnt--;
      busy = (busy_cnt != 0);
      if (sda_oe !== oe_prev && scl) viol++;
    end
    oe_prev = sda_oe;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s act=%0h exp=%0h", tag, act, expv); end
  endtask

  task automatic hw(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic m_start();
    for (int i = 0; i < 256; i++) pv[i] = 1'b0;  // model drops unfinished page
    msda = 1'b1; hw(H); scl = 1'b1; hw(H); msda = 1'b0; hw(H); scl = 1'b0; hw(2);
  endtask

  task automatic m_stop();
    msda = 1'b0; hw(H); scl = 1'b1; hw(H); msda = 1'b1; hw(H);
  endtask

  task automatic m_bit_out(input logic b);
    msda = b; hw(H); scl = 1'b1; hw(H); scl = 1'b0; hw(2);
  endtask

  task automatic m_bit_in(output logic b);
    msda = 1'b1; hw(H); scl = 1'b1; hw(H/2); b = line; hw(H/2); scl = 1'b0; hw(2);
  endtask

  task automatic m_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) m_bit_out(d[i]);
    m_bit_in(b);
    ack = ~b;
  endtask

  task automatic m_rbyte(output logic [7:0] d, input logic send_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin m_bit_in(b); d[i] = b; end
    m_bit_out(~send_ack);
  endtask

  task automatic wait_idle();
    hw(3);
    while (busy) hw(1);
    hw(5);
  endtask

  task automatic do_write(input logic [7:0] a, input int n, input string tag);
    logic ak;
    logic [7:0] d;
    int c0;
    c0 = commit_cnt;
    m_start();
    m_byte({4'b1010, CS, 1'b0}, ak); chk(ak, {tag, " sel ack"}, ak, 1);
    m_byte(a, ak);                   chk(ak, {tag, " addr ack"}, ak, 1);
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      m_byte(d, ak); chk(ak, {tag, " data ack"}, ak, 1);
      expm[{a[7:4], a[3:0] + 4'(i)}] = d;
    end
    m_stop();
    hw(4);
    chk(commit_cnt == c0 + 1 && !last_prot, {tag, " commit"}, commit_cnt - c0, 1);
    exp_ptr = {a[7:4], a[3:0] + 4'(n)};
    wait_idle();
  endtask

  task automatic do_read(input bit rnd, input logic [7:0] a, input int n, input string tag);
    logic ak;
    logic [7:0] d, p;
    m_start();
    if (rnd) begin
      m_byte({4'b1010, CS, 1'b0}, ak); chk(ak, {tag, " dummy sel"}, ak, 1);
      m_byte(a, ak);                   chk(ak, {tag, " dummy addr"}, ak, 1);
      m_start();
      p = a;
    end else p = exp_ptr;
    m_byte({4'b1010, CS, 1'b1}, ak); chk(ak, {tag, " read sel"}, ak, 1);
    for (int i = 0; i < n; i++) begin
      m_rbyte(d, i < n - 1);
      chk(d == expm[8'(p + 8'(i))], {tag, " read data"}, d, expm[8'(p + 8'(i))]);
    end
    m_stop();
    exp_ptr = 8'(p + 8'(n));
    hw(5);
  endtask

  initial begin
    logic ak, b;
    logic [7:0] d;
    int c0, w0, hi;
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'($urandom); expm[i] = mem[i]; pv[i] = 1'b0;
    end
    hw(10); rst_n = 1'b1; hw(10);

    chk(sda_oe == 1'b0, "R1 oe after reset", sda_oe, 0);
    chk(we_cnt == 0 && commit_cnt == 0, "R1 no strobes", we_cnt + commit_cnt, 0);

    do_write(8'h12, 1, "R3");
    do_write(8'h3D, 5, "R4");
    do_read(1'b1, 8'h30, 16, "R4 readback");
    do_read(1'b0, 8'h00, 3, "R6");
    do_read(1'b1, 8'h12, 1, "R7");
    do_read(1'b1, 8'hFE, 4, "R8 wrap");

    // R8: NoAck, then the slave keeps the line free until START
    m_start();
    m_byte({4'b1010, CS, 1'b1}, ak); chk(ak, "R8 sel", ak, 1);
    m_rbyte(d, 1'b0); chk(d == expm[exp_ptr], "R8 data", d, expm[exp_ptr]);
    exp_ptr = exp_ptr + 8'd1;
    hi = 0;
    for (int i = 0; i < 9; i++) begin m_bit_in(b); if (b) hi++; end
    chk(hi == 9, "R8 released after NoAck", hi, 9);
    m_stop(); hw(5);

    // R2: wrong chip bits and wrong type code
    w0 = we_cnt; c0 = commit_cnt;
    m_start();
    m_byte({4'b1010, CS ^ 3'b001, 1'b0}, ak); chk(!ak, "R2 chip mismatch", ak, 0);
    m_byte(8'h40, ak); chk(!ak, "R2 addr ignored", ak, 0);
    m_byte(8'h5A, ak); chk(!ak, "R2 data ignored", ak, 0);
    m_stop(); hw(4);
    chk(we_cnt == w0 && commit_cnt == c0, "R2 no write", we_cnt - w0, 0);
    m_start();
    m_byte({4'b1011, CS, 1'b1}, ak); chk(!ak, "R2 type mismatch", ak, 0);
    m_stop(); hw(5);

    // R5: address-only write loads counter, no commit
    c0 = commit_cnt;
    m_start();
    m_byte({4'b1010, CS, 1'b0}, ak); m_byte(8'h50, ak);
    m_stop(); hw(4);
    chk(commit_cnt == c0, "R5 addr-only stop", commit_cnt - c0, 0);
    exp_ptr = 8'h50;
    do_read(1'b0, 8'h00, 1, "R5 counter loaded");
    // R5: stop three bits into the next byte
    m_start();
    m_byte({4'b1010, CS, 1'b0}, ak); m_byte(8'h60, ak); m_byte(~expm[8'h60], ak);
    m_bit_out(1'b1); m_bit_out(1'b0); m_bit_out(1'b1);
    m_stop(); hw(4);
    chk(commit_cnt == c0, "R5 mid-byte stop", commit_cnt - c0, 0);
    do_read(1'b1, 8'h60, 2, "R5 memory unchanged");

    // R9: protection register
    w0 = we_cnt; c0 = commit_cnt;
    m_start();
    m_byte({4'b0110, CS, 1'b0}, ak); chk(ak, "R9 prot sel", ak, 1);
    m_byte(8'h00, ak);               chk(ak, "R9 prot addr", ak, 1);
    m_byte(8'h00, ak);               chk(ak, "R9 prot data", ak, 1);
    m_stop(); hw(4);
    chk(commit_cnt == c0 + 1 && last_prot, "R9 prot commit", last_prot, 1);
    chk(we_cnt == w0, "R9 no array write", we_cnt - w0, 0);
    wait_idle();
    m_start();
    m_byte({4'b0110, CS, 1'b1}, ak); chk(!ak, "R9 prot read refused", ak, 0);
    m_stop(); hw(5);

    // R10: poll during the self-timed write
    m_start();
    m_byte({4'b1010, CS, 1'b0}, ak); m_byte(8'h77, ak);
    d = 8'($urandom); m_byte(d, ak); expm[8'h77] = d;
    m_stop(); hw(2);
    chk(busy == 1'b1, "R10 busy raised", busy, 1);
    m_start();
    m_byte({4'b1010, CS, 1'b0}, ak); chk(!ak, "R10 poll nack while busy", ak, 0);
    m_stop();
    wait_idle();
    m_start();
    m_byte({4'b1010, CS, 1'b0}, ak); chk(ak, "R10 poll ack when idle", ak, 1);
    m_byte(8'h77, ak);
    m_stop(); hw(5);
    exp_ptr = 8'h77;
    do_read(1'b0, 8'h00, 1, "R10 data landed");

    // R11: START mid-byte
    m_start();
    m_bit_out(1'b1); m_bit_out(1'b0); m_bit_out(1'b1); m_bit_out(1'b0);
    m_start();
    m_byte({4'b1010, CS, 1'b1}, ak); chk(ak, "R11 restart sel", ak, 1);
    m_rbyte(d, 1'b0); chk(d == expm[exp_ptr], "R11 data", d, expm[exp_ptr]);
    exp_ptr = exp_ptr + 8'd1;
    m_stop(); hw(5);

    // random mix
    for (int k = 0; k < 12; k++) begin
      int op;
      op = int'($urandom % 3);
      if (op == 0)      do_write(8'($urandom), 1 + int'($urandom % 16), "R4 rand write");
      else if (op == 1) do_read(1'b1, 8'($urandom), 1 + int'($urandom % 8), "R8 rand read");
      else              do_read(1'b0, 8'h00, 1 + int'($urandom % 4), "R6 rand cur read");
    end

    chk(viol == 0, "R12 drive changes with clock high", viol, 0);

    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule